// File: doc/BRIEF.md
# Dual-Width Integer ALU Flag Stage

This block is the integer execute stage of a 64-bit datapath. It combines two operands under an add, subtract, bitwise-logic or set-high operation. In the same pass it derives two complete negative/zero/overflow/carry flag sets: one for the low 32-bit view of the result and one for the full 64-bit view. The result and the write-enable for the flags are combinational. The 8-bit condition-code byte is held in a register that loads only when a valid operation asks for a flag update.

Operand B is either the register operand or a sign-extended immediate. The immediate field is 13 bits wide and may be read as a 10-, 11- or 13-bit signed value. Subtraction is computed as A plus the complement of B plus one, and its carry is reported with borrow polarity. A result-only flag mode keeps zero and negative but clears both carries and both overflows. The set-high operation never touches the flags. When it names destination 0 with a zero immediate, the block marks it as a no-operation.

Top module: `intalu_flagstage`

## Requirements
- R1: The condition-code register `cc_q` resets to 0x00. Its bit layout from bit 0 upward is: c32, v32, z32, n32, c64, v64, z64, n64. On a rising edge with `cc_we` high it loads the flag byte of the current operation.
- R2: n32 equals result bit 31 and n64 equals result bit 63.
- R3: z32 is set when result bits 31:0 are all zero. z64 is set only when all 64 result bits are zero.
- R4: For ADD (op 0), c32 and c64 are the carry out of the unsigned sum at widths 32 and 64. v32 and v64 are set when both operands share the sign bit at width-1 and the result's sign bit differs from it.
- R5: For SUB (op 1), the result is A-B. c32 and c64 are set when A is unsigned-less-than B at that width (borrow). v is computed as for ADD with B complemented.
- R6: AND (2), OR (3), XOR (4), AND-NOT (5, A&~B) and OR-NOT (6, A|~B) produce the bitwise result. Their carry and overflow flags are zero.
- R7: With flag mode 2 (result-only), zero and negative flags are computed normally and all four carry/overflow bits are zero.
- R8: With flag mode 0 or 3, or with `valid` low, `cc_we` is low and `cc_q` keeps its value. Mode 1 is full flag computation.
- R9: When `use_imm` is high, operand B is `imm_field` sign-extended from 10 bits (select 0), 11 bits (select 1) or 13 bits (select 2 or 3).
- R10: SETHI (op 7) gives a result with bits 31:10 equal to `sethi_imm`, bits 9:0 zero and bits 63:32 zero. `cc_we` is low for SETHI in every mode.
- R11: `is_nop` is high only for SETHI with `dest_idx` 0 and `sethi_imm` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Operation completes this cycle |
| op_sel | input | 3 | Operation code |
| flag_mode | input | 2 | 0/3 none, 1 full, 2 result-only |
| use_imm | input | 1 | Take operand B from the immediate |
| imm_width_sel | input | 2 | Immediate width select |
| imm_field | input | 13 | Raw immediate field |
| sethi_imm | input | 22 | Set-high immediate |
| dest_idx | input | 5 | Destination register index |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register operand B |
| result | output | 64 | Operation result |
| cc_we | output | 1 | Condition-code write enable |
| cc_q | output | 8 | Registered condition-code byte |
| is_nop | output | 1 | Set-high decoded as no-operation |

## Verification
A wrong carry chain, sign compare or borrow inversion shows up as a wrong bit in `cc_q` one edge after the operation. A wrong result path appears on `result` in the same cycle. The bench sweeps operand pairs that sit on the 32- and 64-bit sign and carry boundaries, across all operations and flag modes. Because a stale or wrongly enabled register would surface on the following edge, it compares `cc_q` after every operation, including the ones that must not write it. All 8192 immediate fields are swept at every width select.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
    localparam int XLEN    = 64;
    localparam int HLEN    = 32;
    localparam int IMM_W   = 13;
    localparam int SETHI_W = 22;
    localparam int SETHI_LO = 10;
    localparam int REGIDX_W = 5;
    localparam int NUM_VIEWS = 2;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_ANDN  = 3'd5,
        OP_ORN   = 3'd6,
        OP_SETHI = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        FM_NONE    = 2'd0,
        FM_FULL    = 2'd1,
        FM_RESONLY = 2'd2,
        FM_NONE2   = 2'd3
    } flag_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_set_t;

    typedef struct packed {
        logic [7:0] cc;
    } cc_state_t;
endpackage

// File: rtl/intalu_imm_ext.sv
module intalu_imm_ext #(
    parameter int DW      = 64,
    parameter int FIELD_W = 13
) (
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [1:0]         width_sel,
    output logic [DW-1:0]      imm_ext
);
    localparam int NARROW_W = FIELD_W - 3;
    localparam int MID_W    = FIELD_W - 2;

    always_comb begin
        unique case (width_sel)
            2'd0:    imm_ext = {{(DW-NARROW_W){imm_field[NARROW_W-1]}}, imm_field[NARROW_W-1:0]};
            2'd1:    imm_ext = {{(DW-MID_W){imm_field[MID_W-1]}}, imm_field[MID_W-1:0]};
            default: imm_ext = {{(DW-FIELD_W){imm_field[FIELD_W-1]}}, imm_field};
        endcase
    end
endmodule

// File: rtl/intalu_datapath.sv
module intalu_datapath
    import intalu_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int SW = SETHI_W,
    parameter int SL = SETHI_LO
) (
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [SW-1:0] sethi_imm,
    output logic [DW-1:0] res,
    output logic [DW-1:0] b_eff,
    output logic          cin,
    output logic          is_arith
);
    localparam int HI_PAD = DW - SW - SL;

    alu_op_e op;
    logic [DW-1:0] sum;

    always_comb begin
        op       = alu_op_e'(op_sel);
        cin      = (op == OP_SUB);
        b_eff    = (op == OP_SUB) ? ~b : b;
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        sum      = a + b_eff + {{(DW-1){1'b0}}, cin};
        unique case (op)
            OP_ADD, OP_SUB: res = sum;
            OP_AND:         res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_ANDN:        res = a & ~b;
            OP_ORN:         res = a | ~b;
            default:        res = {{HI_PAD{1'b0}}, sethi_imm, {SL{1'b0}}};
        endcase
    end
endmodule

// File: rtl/intalu_flag_gen.sv
module intalu_flag_gen
    import intalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    input  logic [W-1:0] res,
    input  logic         borrow_mode,
    input  logic         kill_cv,
    output flag_set_t    flags
);
    logic [W:0] wide_sum;
    logic       raw_c;
    logic       raw_v;

    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        raw_c    = wide_sum[W] ^ borrow_mode;
        raw_v    = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
        flags.n  = res[W-1];
        flags.z  = (res == '0);
        flags.c  = kill_cv ? 1'b0 : raw_c;
        flags.v  = kill_cv ? 1'b0 : raw_v;
    end
endmodule

// File: rtl/intalu_flagstage.sv
module intalu_flagstage
    import intalu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [2:0]          op_sel,
    input  logic [1:0]          flag_mode,
    input  logic                use_imm,
    input  logic [1:0]          imm_width_sel,
    input  logic [IMM_W-1:0]    imm_field,
    input  logic [SETHI_W-1:0]  sethi_imm,
    input  logic [REGIDX_W-1:0] dest_idx,
    input  logic [XLEN-1:0]     opa,
    input  logic [XLEN-1:0]     opb,
    output logic [XLEN-1:0]     result,
    output logic                cc_we,
    output logic [7:0]          cc_q,
    output logic                is_nop
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] b_sel;
    logic [XLEN-1:0] b_eff;
    logic            cin;
    logic            is_arith;
    logic            kill_cv;
    flag_set_t       view_flags [NUM_VIEWS];
    logic [7:0]      cc_byte;
    cc_state_t       state_d, state_q;

    intalu_imm_ext #(.DW(XLEN), .FIELD_W(IMM_W)) u_imm (
        .imm_field (imm_field),
        .width_sel (imm_width_sel),
        .imm_ext   (imm_ext)
    );

    assign b_sel = use_imm ? imm_ext : opb;

    intalu_datapath #(.DW(XLEN), .SW(SETHI_W), .SL(SETHI_LO)) u_dp (
        .op_sel    (op_sel),
        .a         (opa),
        .b         (b_sel),
        .sethi_imm (sethi_imm),
        .res       (result),
        .b_eff     (b_eff),
        .cin       (cin),
        .is_arith  (is_arith)
    );

    assign kill_cv = !is_arith || (flag_mode_e'(flag_mode) == FM_RESONLY);

    for (genvar g = 0; g < NUM_VIEWS; g++) begin : g_view
        localparam int VW = (g == 0) ? HLEN : XLEN;
        intalu_flag_gen #(.W(VW)) u_fg (
            .a           (opa[VW-1:0]),
            .b_eff       (b_eff[VW-1:0]),
            .cin         (cin),
            .res         (result[VW-1:0]),
            .borrow_mode (cin),
            .kill_cv     (kill_cv),
            .flags       (view_flags[g])
        );
    end

    always_comb begin
        cc_byte = {view_flags[1].n, view_flags[1].z, view_flags[1].v, view_flags[1].c,
                   view_flags[0].n, view_flags[0].z, view_flags[0].v, view_flags[0].c};
        cc_we   = valid
                  && (alu_op_e'(op_sel) != OP_SETHI)
                  && ((flag_mode_e'(flag_mode) == FM_FULL) || (flag_mode_e'(flag_mode) == FM_RESONLY));
        is_nop  = (alu_op_e'(op_sel) == OP_SETHI) && (dest_idx == '0) && (sethi_imm == '0);
        state_d = state_q;
        if (cc_we) begin
            state_d.cc = cc_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cc_q = state_q.cc;

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |=> $stable(cc_q)) else $error("cc_q changed without write enable"); // R8
    AST_CC_NEG64: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> (cc_q[7] == $past(result[63])) && (cc_q[3] == $past(result[31]))) else $error("negative flag mismatch"); // R2
    AST_RESONLY_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_we && flag_mode == 2'd2) |=> (cc_q[5:4] == 2'b00) && (cc_q[1:0] == 2'b00)) else $error("result-only mode left C/V set"); // R7
    AST_SETHI_NOWE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |-> !cc_we && (result[9:0] == '0)) else $error("set-high wrote flags or low bits"); // R10
    AST_ZERO64: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_we && result == '0) |=> cc_q[6] && cc_q[2]) else $error("zero flags not set on zero result"); // R3
endmodule

// File: tb/intalu_flagstage_tb.sv
module intalu_flagstage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  flag_mode = '0;
    logic        use_imm = 1'b0;
    logic [1:0]  imm_width_sel = '0;
    logic [12:0] imm_field = '0;
    logic [21:0] sethi_imm = '0;
    logic [4:0]  dest_idx = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] result;
    logic        cc_we;
    logic [7:0]  cc_q;
    logic        is_nop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model_cc = 8'h00;

    intalu_flagstage u_dut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op_sel(op_sel), .flag_mode(flag_mode),
        .use_imm(use_imm), .imm_width_sel(imm_width_sel), .imm_field(imm_field),
        .sethi_imm(sethi_imm), .dest_idx(dest_idx), .opa(opa), .opb(opb),
        .result(result), .cc_we(cc_we), .cc_q(cc_q), .is_nop(is_nop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] sext(input logic [12:0] f, input logic [1:0] sel);
        int w;
        logic [63:0] v;
        w = (sel == 2'd0) ? 10 : (sel == 2'd1) ? 11 : 13;
        v = {51'b0, f} & ((64'd1 << w) - 64'd1);
        if (v[w-1]) v = v - (64'd1 << w);
        return v;
    endfunction

    function automatic logic [63:0] exp_res(input logic [2:0] op, input logic [63:0] a,
                                             input logic [63:0] b, input logic [21:0] sh);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a & ~b;
            3'd6: return a | ~b;
            default: return {32'b0, sh, 10'b0};
        endcase
    endfunction

    function automatic logic [7:0] exp_cc(input logic [2:0] op, input logic [1:0] md,
                                          input logic [63:0] a, input logic [63:0] b, input logic [63:0] r);
        logic [32:0] s32;
        logic [64:0] s64;
        logic c32, c64, v32, v64;
        s32 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
        s64 = {1'b0, a} + {1'b0, b};
        if (op == 3'd0) begin
            c32 = s32[32]; c64 = s64[64];
            v32 = (a[31] == b[31]) && (r[31] != a[31]);
            v64 = (a[63] == b[63]) && (r[63] != a[63]);
        end else if (op == 3'd1) begin
            c32 = a[31:0] < b[31:0]; c64 = a < b;
            v32 = (a[31] != b[31]) && (r[31] != a[31]);
            v64 = (a[63] != b[63]) && (r[63] != a[63]);
        end else begin
            c32 = 0; c64 = 0; v32 = 0; v64 = 0;
        end
        if (md == 2'd2) begin c32 = 0; c64 = 0; v32 = 0; v64 = 0; end
        return {r[63], r == 64'd0, v64, c64, r[31], r[31:0] == 32'd0, v32, c32};
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [1:0] md, input logic [63:0] a,
                          input logic [63:0] b, input logic ui, input logic [1:0] ws,
                          input logic [12:0] imf, input logic [21:0] sh, input logic [4:0] rd,
                          input logic vl, input string tag);
        logic [63:0] bb, r;
        logic we;
        @(negedge clk);
        op_sel = op; flag_mode = md; opa = a; opb = b; use_imm = ui; imm_width_sel = ws;
        imm_field = imf; sethi_imm = sh; dest_idx = rd; valid = vl;
        #1;
        bb = ui ? sext(imf, ws) : b;
        r  = exp_res(op, a, bb, sh);
        we = vl && (op != 3'd7) && (md == 2'd1 || md == 2'd2);
        chk({tag, " result"}, result, r);
        chk({tag, " cc_we R8"}, {63'b0, cc_we}, {63'b0, we});
        chk({tag, " is_nop R11"}, {63'b0, is_nop}, {63'b0, (op == 3'd7) && rd == 0 && sh == 0});
        if (we) model_cc = exp_cc(op, md, a, bb, r);
        @(posedge clk); #1;
        chk({tag, " cc_q"}, {56'b0, cc_q}, {56'b0, model_cc});
    endtask

    localparam int NV = 10;
    logic [63:0] corners [NV];

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        corners[0] = 64'h0; corners[1] = 64'h1; corners[2] = 64'h0000_0000_7FFF_FFFF;
        corners[3] = 64'h0000_0000_8000_0000; corners[4] = 64'h0000_0000_FFFF_FFFF;
        corners[5] = 64'h0000_0001_0000_0000; corners[6] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[7] = 64'h8000_0000_0000_0000; corners[8] = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[9] = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset cc_q", {56'b0, cc_q}, 64'h0);
        rst_n = 1'b1;

        // R4 R5 R6 R7 R2 R3 R1: corner operand pairs, all ALU ops, full and result-only modes
        for (int op = 0; op < 7; op++)
            for (int md = 1; md < 3; md++)
                for (int i = 0; i < NV; i++)
                    for (int j = 0; j < NV; j++)
                        run_op(op[2:0], md[1:0], corners[i], corners[j], 1'b0, 2'd0, 13'd0,
                               22'd0, 5'd1, 1'b1,
                               op == 0 ? "R4 add" : op == 1 ? "R5 sub" : md == 2 ? "R7 resonly" : "R6 logic");

        // R8: no-update modes and invalid cycles leave cc_q untouched
        for (int i = 0; i < NV; i++) begin
            run_op(3'd0, 2'd0, corners[i], corners[8], 1'b0, 2'd0, 13'd0, 22'd0, 5'd1, 1'b1, "R8 mode0");
            run_op(3'd1, 2'd3, corners[i], corners[1], 1'b0, 2'd0, 13'd0, 22'd0, 5'd1, 1'b1, "R8 mode3");
            run_op(3'd1, 2'd1, corners[i], corners[3], 1'b0, 2'd0, 13'd0, 22'd0, 5'd1, 1'b0, "R8 invalid");
        end

        // R9: every immediate field at every width select, flags off
        for (int ws = 0; ws < 4; ws++)
            for (int f = 0; f < 8192; f++)
                run_op(3'd0, 2'd0, 64'd0, 64'hDEAD_BEEF_0000_0000, 1'b1, ws[1:0], f[12:0],
                       22'd0, 5'd1, 1'b1, "R9 imm");
        // R9 with flags: immediate subtract
        for (int f = 0; f < 64; f++)
            run_op(3'd1, 2'd1, corners[f % NV], 64'd0, 1'b1, 2'd0, 13'(f * 37), 22'd0, 5'd1, 1'b1, "R9 R5 imm sub");

        // R10 R11: set-high in every mode, nop detection
        run_op(3'd0, 2'd1, corners[8], corners[1], 1'b0, 2'd0, 13'd0, 22'd0, 5'd1, 1'b1, "R10 preset");
        for (int k = 0; k < 40; k++)
            run_op(3'd7, k[1:0], 64'd0, 64'd0, 1'b0, 2'd0, 13'd0,
                   (k < 8) ? 22'd0 : 22'(k * 104729), 5'(k % 3), 1'b1, "R10 R11 sethi");
        run_op(3'd7, 2'd1, 64'd0, 64'd0, 1'b0, 2'd0, 13'd0, 22'h3FFFFF, 5'd0, 1'b1, "R10 sethi max");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule